// File: doc/BRIEF.md
# Variable-Width CRC-CCITT Engine

This block keeps a running 16-bit CRC over the generator x^16 + x^12 + x^5 + 1 (0x1021). A processor writes a starting value of its choice and then appends data words to the same running checksum. Each write picks 8, 16 or 32 bits, and words of different widths may follow one another in any order. The current checksum is always visible on a read port.

Every accepted write takes effect in a single clock. The new result is on the output from the cycle after acceptance. Data bits enter most significant bit first, so a wider word gives the same result as its bytes fed one at a time from the highest byte down. The result is the raw shift register. It is not reflected and no final XOR is applied.

Top module: `crcv_engine`

## Requirements
- R1: After reset `crc_out` is 0xFFFF, which is the default of parameter `INIT_VAL`.
- R2: A write with `wr_seed` = 1 loads `wr_data[15:0]` into the checksum, and `crc_out` shows it from the next cycle. In a seed write, `wr_size` and `wr_data[31:16]` have no effect.
- R3: A write with `wr_seed` = 0 and `wr_size` = 2'b00 appends the byte `wr_data[7:0]`, MSB first, under polynomial 0x1021. Bits `wr_data[31:8]` have no effect.
- R4: `wr_size` = 2'b01 appends `wr_data[15:0]`, high byte first. Bits `wr_data[31:16]` have no effect.
- R5: `wr_size` = 2'b10 appends all of `wr_data[31:0]`, starting from the byte in bits 31:24.
- R6: `wr_size` = 2'b11 is reserved: such a write is accepted and leaves `crc_out` unchanged.
- R7: Seed 0xFFFF followed by the ASCII bytes "123456789" yields 0x29B1. The result is the same whether the bytes are appended singly or packed into 16-bit and 32-bit words in any mix.
- R8: `wr_ready` is high in every cycle out of reset. In a cycle without `wr_valid`, `crc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write may be accepted |
| wr_seed | input | 1 | 1 loads a start value; 0 appends data |
| wr_size | input | 2 | Data width: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| wr_data | input | 32 | Seed value or data word, right-aligned |
| crc_out | output | 16 | Current checksum |

## Verification
The assertions assume that the write-port inputs hold settled, known values at every rising edge while `wr_valid` is high. They also assume that no write is made during reset. The bench changes inputs only on falling edges and keeps `wr_valid` low until reset is released. Reserved sizes and junk in the unused upper data bits are driven on purpose, because the block defines both as having no effect.

// File: rtl/crcv_pkg.sv
package crcv_pkg;

  localparam int          CRC_W = 16;
  localparam logic [15:0] POLY  = 16'h1021;

  typedef enum logic [1:0] {
    SZ_B8   = 2'b00,
    SZ_B16  = 2'b01,
    SZ_B32  = 2'b10,
    SZ_RSVD = 2'b11
  } wsize_e;

  // one serial step: data bit enters against the register MSB
  function automatic logic [CRC_W-1:0] crc_bit(logic [CRC_W-1:0] c, logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

endpackage

// File: rtl/crcv_lane.sv
module crcv_lane
  import crcv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [W-1:0]     data_in,
  output logic [CRC_W-1:0] crc_nx
);
  // unrolled XOR network, MSB of the word first
  always_comb begin
    logic [CRC_W-1:0] acc;
    acc = crc_in;
    for (int i = W - 1; i >= 0; i--) begin
      acc = crc_bit(acc, data_in[i]);
    end
    crc_nx = acc;
  end
endmodule

// File: rtl/crcv_sel.sv
module crcv_sel
  import crcv_pkg::*;
#(
  parameter int NLANE  = 3,
  parameter int DATA_W = 32
) (
  input  logic                        wr_fire,
  input  logic                        wr_seed,
  input  logic [1:0]                  wr_size,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NLANE-1:0][CRC_W-1:0] lane_res,
  output logic                        upd_en,
  output logic [CRC_W-1:0]            crc_next
);
  wsize_e sz;
  assign sz = wsize_e'(wr_size);

  always_comb begin
    upd_en   = 1'b0;
    crc_next = '0;
    if (wr_fire) begin
      if (wr_seed) begin
        upd_en   = 1'b1;
        crc_next = wr_data[CRC_W-1:0];
      end else begin
        unique case (sz)
          SZ_B8:   begin upd_en = 1'b1; crc_next = lane_res[0]; end
          SZ_B16:  begin upd_en = 1'b1; crc_next = lane_res[1]; end
          SZ_B32:  begin upd_en = 1'b1; crc_next = lane_res[2]; end
          default: begin upd_en = 1'b0; crc_next = '0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/crcv_engine.sv
module crcv_engine
  import crcv_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [15:0] INIT_VAL = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_seed,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int NLANE = 3;

  logic [CRC_W-1:0]            crc_q;
  logic [NLANE-1:0][CRC_W-1:0] lane_res;
  logic                        wr_fire;
  logic                        upd_en;
  logic [CRC_W-1:0]            crc_next;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = 8 << g;
    crcv_lane #(.W(LW)) lane_i (
      .crc_in (crc_q),
      .data_in(wr_data[LW-1:0]),
      .crc_nx (lane_res[g])
    );
  end

  crcv_sel #(.NLANE(NLANE), .DATA_W(DATA_W)) sel_i (
    .wr_fire (wr_fire),
    .wr_seed (wr_seed),
    .wr_size (wr_size),
    .wr_data (wr_data),
    .lane_res(lane_res),
    .upd_en  (upd_en),
    .crc_next(crc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT_VAL;
    else if (upd_en) crc_q <= crc_next;
  end

  assign crc_out = crc_q;

  // R8: no write, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(crc_out));

  // R2: seed value appears the next cycle
  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_seed) |=> crc_out == $past(wr_data[15:0]));

  // R6: reserved size leaves the result alone
  p_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_seed && wr_size == 2'b11) |=> $stable(crc_out));

  // R3: zero register with zero byte stays zero (linearity)
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_seed && wr_size == 2'b00 && crc_out == '0 &&
     wr_data[7:0] == 8'h00) |=> crc_out == '0);

  // R8: an accepted append always loads the register
  p_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_seed && wr_size != 2'b11) |-> upd_en);
endmodule

// File: tb/crcv_engine_tb.sv
`timescale 1ns/1ps
module crcv_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_seed = 1'b0;
  logic [1:0]  wr_size = 2'b00;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic [15:0] crc_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_crc = 16'hFFFF;
  string       cur_req = "R1";
  bit          done = 1'b0;

  always #4 clk = ~clk;

  crcv_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_seed(wr_seed), .wr_size(wr_size), .wr_data(wr_data), .crc_out(crc_out)
  );

  // reference: classic byte-wise long division on integers
  function automatic logic [15:0] ref_append(logic [15:0] c, logic [31:0] d, int nbytes);
    int r;
    r = c;
    for (int b = nbytes - 1; b >= 0; b--) begin
      r = r ^ (((d >> (8 * b)) & 32'hFF) << 8);
      for (int k = 0; k < 8; k++) begin
        if ((r & 32'h8000) != 0) r = ((r << 1) ^ 32'h1021) & 32'hFFFF;
        else                     r = (r << 1) & 32'hFFFF;
      end
    end
    return r[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: crc_out=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, crc_out, exp_crc);
      n_cmp++;
      if (wr_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL R8: wr_ready=%b expected=1", wr_ready);
      end
    end
  end

  task automatic wr(string req, bit seed, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    cur_req  = req;
    wr_valid = 1'b1; wr_seed = seed; wr_size = sz; wr_data = d;
    @(posedge clk);
    #1;
    if (seed)              exp_crc = d[15:0];
    else if (sz == 2'b00)  exp_crc = ref_append(exp_crc, d, 1);
    else if (sz == 2'b01)  exp_crc = ref_append(exp_crc, d, 2);
    else if (sz == 2'b10)  exp_crc = ref_append(exp_crc, d, 4);
    @(negedge clk);
    wr_valid = 1'b0; wr_data = 32'hDEAD_BEEF; wr_size = 2'b10;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    check("R1", crc_out, 16'hFFFF);
    rst_n = 1'b1;
    idle(2);
    check("R1", crc_out, 16'hFFFF);

    // R7 check value, byte by byte
    wr("R2", 1'b1, 2'b10, 32'h5A5A_FFFF);
    for (int i = 0; i < 9; i++) wr("R7", 1'b0, 2'b00, 32'hA5A5_A500 | (32'h31 + i));
    check("R7", crc_out, 16'h29B1);

    // R7 mixed widths: "12" | "3456" | '7' | "89"
    wr("R2", 1'b1, 2'b11, 32'h0000_FFFF);
    wr("R4", 1'b0, 2'b01, 32'hFFFF_3132);
    wr("R5", 1'b0, 2'b10, 32'h3334_3536);
    wr("R3", 1'b0, 2'b00, 32'h1234_5637);
    wr("R4", 1'b0, 2'b01, 32'h0000_3839);
    check("R7", crc_out, 16'h29B1);

    // R6 reserved size
    wr("R6", 1'b0, 2'b11, 32'h1234_5678);
    check("R6", crc_out, 16'h29B1);

    // R8 hold over idle cycles
    cur_req = "R8";
    idle(5);
    check("R8", crc_out, 16'h29B1);

    // R2 seed with other patterns, R3 zero case
    wr("R2", 1'b1, 2'b00, 32'hFFFF_0000);
    check("R2", crc_out, 16'h0000);
    wr("R3", 1'b0, 2'b00, 32'hFFFF_FF00);
    check("R3", crc_out, 16'h0000);
    wr("R3", 1'b0, 2'b00, 32'h0000_0001);
    check("R3", crc_out, 16'h1021);

    // varied sequences against the model
    wr("R2", 1'b1, 2'b01, 32'h0000_1D0F);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = 32'h9E37_79B9 * (i + 1) ^ (i << 7);
      wr((i % 3 == 0) ? "R3" : (i % 3 == 1) ? "R4" : "R5", 1'b0, 2'(i % 3), d);
      if (i % 7 == 0) wr("R6", 1'b0, 2'b11, d);
      if (i % 5 == 0) idle(2);
    end
    // R5 against byte-wise equivalent
    wr("R2", 1'b1, 2'b00, 32'h0000_ABCD);
    wr("R5", 1'b0, 2'b10, 32'hCAFE_F00D);
    check("R5", crc_out, ref_append(ref_append(16'hABCD, 32'hCAFE, 2), 32'hF00D, 2));

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule